// File: doc/BRIEF.md
# Port Mirroring Mask Generator

This block sits after the forwarding lookup of a switch. For each frame it takes the forwarding port mask and the index of the port the frame arrived on, and it returns the final egress port mask. When mirroring is enabled, it adds the configured mirror-destination ports if either of these holds: the frame arrived on a port being watched for received traffic, or the frame is headed to a port being watched for transmitted traffic.

Configuration uses two write strobes. A two-bit target select chooses which of three stored masks the next mask write replaces. The three masks are the mirror destinations, the watched receive ports and the watched transmit ports. Mirror destinations only carry mirrored copies. When mirroring is on, ordinary traffic that does not come from a watched source is kept away from them. A frame is never copied back to the port it came in on. Up to 32 ports are supported, and there is one mirror configuration.

Top module: `mirror_mask_gen`

## Requirements
- R1: After reset, all three stored masks are zero and `rsp_valid` is 0. With mirroring enabled and nothing configured, the output mask equals the forwarding mask.
- R2: `rsp_valid` is high for exactly one cycle, in the cycle after a cycle with `req_valid` high. Each response carries the result for that request, and responses come out in request order.
- R3: When `mirror_en` is 0 at request time, the output mask equals the forwarding mask bit for bit.
- R4: A mask write while select bit 0 is 0 replaces the destination mask, whatever the value of select bit 1.
- R5: A mask write while the select is 2'b01 (bit 0 = 1, bit 1 = 0) replaces the receive-source mask. A mask write while the select is 2'b11 replaces the transmit-source mask.
- R6: With mirroring enabled, a frame whose ingress port bit is set in the receive-source mask gets the destination ports added to its output mask.
- R7: With mirroring enabled, a frame whose forwarding mask shares at least one bit with the transmit-source mask gets the destination ports added to its output mask.
- R8: With mirroring enabled, a frame that matches neither source condition has every destination port cleared from its output mask.
- R9: With mirroring enabled, mirroring never sets the bit of the ingress port. That bit is set in the output only if it was set in the forwarding mask and is not a destination port.
- R10: A mask write changes only the mask chosen by the select. The select is held until it is rewritten, and a mask write uses the select value stored before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mirror_en | input | 1 | Global mirroring enable, sampled with each request |
| cfg_sel_we | input | 1 | Write strobe for the target select |
| cfg_sel_wdata | input | 2 | Target select: bit 0 = source (1) or destination (0), bit 1 = transmit (1) or receive (0) |
| cfg_mask_we | input | 1 | Write strobe for the selected mask |
| cfg_mask_wdata | input | NUM_PORTS | New mask value, one bit per port |
| req_valid | input | 1 | Request strobe |
| req_ingress | input | PIDX_W | Ingress port index |
| req_fwd_mask | input | NUM_PORTS | Forwarding port mask from the lookup |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_mask | output | NUM_PORTS | Final egress port mask |

## Verification
The hardest case to reach is a frame that arrives on a watched receive port while its own ingress port is also a mirror destination. The result then depends on the egress-only clearing and on the ingress exclusion acting together. The stimulus reaches it by rewriting the destination mask so that it includes the receive-source port, and then sending a request from that port. A second hard case is a write with select 2'b10: a mask write there must go to the destinations and not to either source. This is shown by later requests that still match the earlier receive and transmit masks.

// File: rtl/mirror_pkg.sv
package mirror_pkg;
   localparam int unsigned MAX_PORTS   = 32;
   localparam int unsigned SEL_W       = 2;
   localparam int unsigned SEL_SRC_BIT = 0;
   localparam int unsigned SEL_DIR_BIT = 1;
   localparam int unsigned NUM_TGT     = 3;

   typedef enum logic [1:0] {
      TGT_DST = 2'd0,
      TGT_RX  = 2'd1,
      TGT_TX  = 2'd2
   } mask_tgt_e;

   function automatic mask_tgt_e decode_sel(input logic [SEL_W-1:0] s);
      if (!s[SEL_SRC_BIT])     return TGT_DST;
      else if (s[SEL_DIR_BIT]) return TGT_TX;
      else                     return TGT_RX;
   endfunction
endpackage

// File: rtl/mirror_cfg_regs.sv
module mirror_cfg_regs
   import mirror_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_sel_we,
   input  logic [SEL_W-1:0]     cfg_sel_wdata,
   input  logic                 cfg_mask_we,
   input  logic [NUM_PORTS-1:0] cfg_mask_wdata,
   output logic [NUM_PORTS-1:0] dst_mask,
   output logic [NUM_PORTS-1:0] rx_mask,
   output logic [NUM_PORTS-1:0] tx_mask
);
   logic [SEL_W-1:0]     sel_q;
   mask_tgt_e            tgt;
   logic [NUM_PORTS-1:0] mask_q [NUM_TGT];

   always_ff @(posedge clk) begin
      if (!rst_n)          sel_q <= '0;
      else if (cfg_sel_we) sel_q <= cfg_sel_wdata;
   end

   assign tgt = decode_sel(sel_q);

   for (genvar k = 0; k < NUM_TGT; k++) begin : g_mask
      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_q[k] <= '0;
         else if (cfg_mask_we && (tgt == mask_tgt_e'(k)))
            mask_q[k] <= cfg_mask_wdata;
      end
   end

   assign dst_mask = mask_q[TGT_DST];
   assign rx_mask  = mask_q[TGT_RX];
   assign tx_mask  = mask_q[TGT_TX];

   // R4: destination replaced whenever select bit 0 is clear
   a_r4_dst_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask_we && !sel_q[SEL_SRC_BIT]) |=> (dst_mask == $past(cfg_mask_wdata)));
   // R5: receive and transmit sources
   a_r5_rx_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask_we && sel_q == 2'b01) |=> (rx_mask == $past(cfg_mask_wdata)));
   a_r5_tx_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask_we && sel_q == 2'b11) |=> (tx_mask == $past(cfg_mask_wdata)));
   // R10: other masks untouched
   a_r10_dst_only: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mask_we && !sel_q[SEL_SRC_BIT]) |=> ($stable(rx_mask) && $stable(tx_mask)));
   a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mask_we |=> ($stable(rx_mask) && $stable(tx_mask) && $stable(dst_mask)));
endmodule

// File: rtl/mirror_hit_detect.sv
module mirror_hit_detect #(
   parameter int unsigned NUM_PORTS = 32,
   parameter int unsigned PIDX_W    = 5
) (
   input  logic [PIDX_W-1:0]    ingress,
   input  logic [NUM_PORTS-1:0] fwd_mask,
   input  logic [NUM_PORTS-1:0] rx_mask,
   input  logic [NUM_PORTS-1:0] tx_mask,
   output logic [NUM_PORTS-1:0] ingress_oh,
   output logic                 rx_hit,
   output logic                 tx_hit
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_oh
      assign ingress_oh[p] = (ingress == PIDX_W'(p));
   end

   assign rx_hit = |(ingress_oh & rx_mask);
   assign tx_hit = |(fwd_mask & tx_mask);

   always_comb begin
      a_oh_single: assert ($onehot0(ingress_oh));
   end
endmodule

// File: rtl/mirror_mask_merge.sv
module mirror_mask_merge #(
   parameter int unsigned NUM_PORTS = 32,
   parameter int unsigned PIDX_W    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mirror_en,
   input  logic                 req_valid,
   input  logic [PIDX_W-1:0]    req_ingress,
   input  logic [NUM_PORTS-1:0] req_fwd_mask,
   input  logic [NUM_PORTS-1:0] ingress_oh,
   input  logic [NUM_PORTS-1:0] dst_mask,
   input  logic                 rx_hit,
   input  logic                 tx_hit,
   output logic                 rsp_valid,
   output logic [NUM_PORTS-1:0] rsp_mask
);
   logic                 hit;
   logic [NUM_PORTS-1:0] base, add, nxt;

   assign hit = rx_hit | tx_hit;

   always_comb begin
      base = req_fwd_mask & ~dst_mask;
      add  = hit ? (dst_mask & ~ingress_oh) : '0;
      nxt  = mirror_en ? (base | add) : req_fwd_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_mask  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) rsp_mask <= nxt;
      end
   end

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r3_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mirror_en) |=> (rsp_mask == $past(req_fwd_mask)));
   a_r8_dst_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mirror_en && !rx_hit && !tx_hit) |=> ((rsp_mask & $past(dst_mask)) == '0));
   a_r6_rx_adds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mirror_en && rx_hit) |=>
         (((rsp_mask | $past(ingress_oh)) & $past(dst_mask)) == $past(dst_mask)));
   a_r9_no_reflect: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mirror_en && !req_fwd_mask[req_ingress]) |=> !rsp_mask[$past(req_ingress)]);
endmodule

// File: rtl/mirror_mask_gen.sv
module mirror_mask_gen
   import mirror_pkg::*;
#(
   parameter int unsigned NUM_PORTS = 32,
   localparam int unsigned PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mirror_en,
   input  logic                 cfg_sel_we,
   input  logic [1:0]           cfg_sel_wdata,
   input  logic                 cfg_mask_we,
   input  logic [NUM_PORTS-1:0] cfg_mask_wdata,
   input  logic                 req_valid,
   input  logic [PIDX_W-1:0]    req_ingress,
   input  logic [NUM_PORTS-1:0] req_fwd_mask,
   output logic                 rsp_valid,
   output logic [NUM_PORTS-1:0] rsp_mask
);
   if (NUM_PORTS < 1 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("mirror_mask_gen: NUM_PORTS out of range");
   end

   logic [NUM_PORTS-1:0] dst_mask, rx_mask, tx_mask, ingress_oh;
   logic                 rx_hit, tx_hit;

   mirror_cfg_regs #(.NUM_PORTS(NUM_PORTS)) u_cfg (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_sel_we     (cfg_sel_we),
      .cfg_sel_wdata  (cfg_sel_wdata),
      .cfg_mask_we    (cfg_mask_we),
      .cfg_mask_wdata (cfg_mask_wdata),
      .dst_mask       (dst_mask),
      .rx_mask        (rx_mask),
      .tx_mask        (tx_mask)
   );

   mirror_hit_detect #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_hit (
      .ingress    (req_ingress),
      .fwd_mask   (req_fwd_mask),
      .rx_mask    (rx_mask),
      .tx_mask    (tx_mask),
      .ingress_oh (ingress_oh),
      .rx_hit     (rx_hit),
      .tx_hit     (tx_hit)
   );

   mirror_mask_merge #(.NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W)) u_merge (
      .clk          (clk),
      .rst_n        (rst_n),
      .mirror_en    (mirror_en),
      .req_valid    (req_valid),
      .req_ingress  (req_ingress),
      .req_fwd_mask (req_fwd_mask),
      .ingress_oh   (ingress_oh),
      .dst_mask     (dst_mask),
      .rx_hit       (rx_hit),
      .tx_hit       (tx_hit),
      .rsp_valid    (rsp_valid),
      .rsp_mask     (rsp_mask)
   );

   // R1: idle output after reset
   a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> (!rsp_valid && rsp_mask == '0));
endmodule

// File: tb/mirror_mask_gen_tb_top.sv
module mirror_mask_gen_tb_top;
   localparam int NP = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mirror_en = 1'b0;
   logic          cfg_sel_we = 1'b0;
   logic [1:0]    cfg_sel_wdata = '0;
   logic          cfg_mask_we = 1'b0;
   logic [NP-1:0] cfg_mask_wdata = '0;
   logic          req_valid = 1'b0;
   logic [4:0]    req_ingress = '0;
   logic [NP-1:0] req_fwd_mask = '0;
   logic          rsp_valid;
   logic [NP-1:0] rsp_mask;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [NP-1:0] m_dst = '0, m_rx = '0, m_tx = '0;
   logic [1:0]    m_sel = '0;
   logic [NP-1:0] exp_q [$];
   int            tag_q [$];

   always #10 clk = ~clk;

   mirror_mask_gen #(.NUM_PORTS(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .mirror_en(mirror_en),
      .cfg_sel_we(cfg_sel_we), .cfg_sel_wdata(cfg_sel_wdata),
      .cfg_mask_we(cfg_mask_we), .cfg_mask_wdata(cfg_mask_wdata),
      .req_valid(req_valid), .req_ingress(req_ingress), .req_fwd_mask(req_fwd_mask),
      .rsp_valid(rsp_valid), .rsp_mask(rsp_mask));

   task automatic check(input bit ok, input int r, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL R%0d actual=%h expected=%h", r, act, exp);
      end
   endtask

   function automatic logic [NP-1:0] model(input logic en, input int ing, input logic [NP-1:0] fwd);
      logic [NP-1:0] oh;
      logic hit;
      oh  = NP'(1) << ing;
      hit = ((oh & m_rx) != '0) || ((fwd & m_tx) != '0);
      if (!en) return fwd;
      return (fwd & ~m_dst) | (hit ? (m_dst & ~oh) : '0);
   endfunction

   task automatic wr_sel(input logic [1:0] s);
      @(negedge clk);
      cfg_sel_we = 1'b1; cfg_sel_wdata = s;
      @(negedge clk);
      cfg_sel_we = 1'b0;
      m_sel = s;
   endtask

   task automatic wr_mask(input logic [NP-1:0] v);
      @(negedge clk);
      cfg_mask_we = 1'b1; cfg_mask_wdata = v;
      @(negedge clk);
      cfg_mask_we = 1'b0;
      if (!m_sel[0])     m_dst = v;
      else if (m_sel[1]) m_tx  = v;
      else               m_rx  = v;
   endtask

   // driver: push expected result, drive the request for one cycle
   task automatic send(input int ing, input logic [NP-1:0] fwd, input int r);
      @(negedge clk);
      req_valid = 1'b1; req_ingress = 5'(ing); req_fwd_mask = fwd;
      exp_q.push_back(model(mirror_en, ing, fwd));
      tag_q.push_back(r);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: compares each response with the head of the queue
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, 2, rsp_mask, '0); // R2: response without request
         end else begin
            logic [NP-1:0] e;
            int r;
            e = exp_q.pop_front();
            r = tag_q.pop_front();
            check(rsp_mask === e, r, rsp_mask, e);
         end
      end
   end

   initial begin
      #(20 * 50000);
      check(1'b0, 0, '0, '0); // watchdog
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(rsp_valid == 1'b0, 1, {31'd0, rsp_valid}, '0);
      check(rsp_mask == '0, 1, rsp_mask, '0);
      mirror_en = 1'b1;
      send(3, 32'h0000_00F0, 1);        // R1: nothing configured
      idle();

      wr_sel(2'b00); wr_mask(32'h0000_0100); // R4 dst = port 8
      wr_sel(2'b01); wr_mask(32'h0000_0002); // R5 rx = port 1
      wr_sel(2'b11); wr_mask(32'h0001_0000); // R5 tx = port 16

      @(negedge clk); mirror_en = 1'b0;
      send(1, 32'h0000_000C, 3);        // R3 bypass with rx hit
      send(2, 32'h0000_0100, 3);        // R3 bypass to dst port
      idle();
      @(negedge clk); mirror_en = 1'b1;
      send(1, 32'h0000_000C, 6);        // R6
      send(4, 32'h0001_0020, 7);        // R7
      send(4, 32'h0000_0120, 8);        // R8
      idle();

      wr_sel(2'b00); wr_mask(32'h0000_0106); // dst includes ingress port 1
      send(1, 32'h0000_0008, 9);        // R9 expect 0x10C
      send(2, 32'h0000_0004, 9);        // R9 ingress 2 is dst, no hit
      idle();

      wr_sel(2'b10); wr_mask(32'h0000_1000); // R4 bit1 ignored
      send(1, 32'h0000_0001, 4);        // R4 new dst used, R10 rx kept
      send(5, 32'h0001_0002, 10);       // R10 tx kept
      idle();

      wr_sel(2'b11); wr_mask(32'h0000_0004); // R5 tx replaced
      send(6, 32'h0000_0004, 5);
      send(6, 32'h0001_0000, 5);        // R5 old tx gone
      // R10 select held: second write still to tx
      idle();
      wr_mask(32'h0000_0008);
      send(7, 32'h0000_0008, 10);
      send(7, 32'h0000_0004, 10);
      send(0, 32'hFFFF_FFFF, 2);        // R2 back-to-back
      idle();
      repeat (2) @(negedge clk);
      #1;
      check(rsp_valid == 1'b0, 2, {31'd0, rsp_valid}, '0); // R2 single pulse
      check(exp_q.size() == 0, 2, NP'(exp_q.size()), '0);  // R2 all answered
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule